// File: doc/BRIEF.md
# Sized Request Boundary Splitter

This block turns one host transfer descriptor into an ordered series of link-legal sized read or write requests. A descriptor names a 40-bit start address, a direction and either a byte length or, in sparse mode, a 32-bit byte-enable pattern over one aligned 32-byte window. The splitter issues the whole-dword body of a transfer as dword requests. Each dword request is as long as possible without running past a 64-byte boundary. Any unaligned head or tail is sent as byte requests. Sparse descriptors become byte requests whose masks may have gaps.

Each request carries address bits 39 down to 2, a request kind, a dword count and a byte mask. Descriptors enter and requests leave through valid/ready handshakes. The splitter holds one descriptor at a time and stays busy until that descriptor's last request has been accepted. It does not carry payload data, make posting decisions or track responses.

Top module: `sized_req_splitter`

## Requirements
- R1: After reset, `req_valid` is 0 and `desc_ready` is 1.
- R2: A descriptor is taken on a cycle where `desc_valid` and `desc_ready` are both high. `desc_ready` stays low while any request of that descriptor is still pending. While `req_valid` is high and `req_ready` is low, all request outputs keep their values.
- R3: `req_kind` encodes 0 = byte read, 1 = dword read, 2 = byte write, 3 = dword write. `req_addr` holds bits 39:2 of the first addressed dword. For dword requests, `req_dcnt` is the dword count minus one and `req_bmask` is zero. For byte requests, `req_dcnt` is zero.
- R4: A dword request never crosses a 64-byte boundary, so `req_addr[3:0] + req_dcnt` is at most 15.
- R5: In length mode, when the current address is dword-aligned and at least 4 bytes remain, a dword request is issued. Its count is the smaller of the number of dwords left before the next 64-byte boundary and the number of whole dwords remaining.
- R6: In length mode, when the current address is not dword-aligned or fewer than 4 bytes remain, a byte request is issued. It covers the bytes from the current address up to the next dword boundary or the end of the transfer. In a byte read mask, bit k is byte k of the dword and bits 31:4 are zero. In a byte write mask, bit b is byte b of the aligned 32-byte block.
- R7: Requests come out in ascending address order, one per accepted handshake, and together cover each byte of the transfer exactly once.
- R8: A length-mode descriptor with length 0 produces no request, and `desc_ready` is 1 again on the next cycle.
- R9: A sparse read produces one byte read for each dword of the window whose 4-bit mask nibble is nonzero, in ascending order, each carrying that nibble. Address bits 4:0 of the descriptor are ignored in sparse mode.
- R10: A sparse write produces a single byte write that carries the whole 32-bit pattern. Its address is the lowest dword of the window that has an enabled byte.
- R11: A sparse descriptor with an all-zero pattern produces no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Splitter idle, descriptor can be taken |
| desc_addr | input | 40 | Start byte address (bits 39:5 only in sparse mode) |
| desc_len | input | LEN_W | Transfer length in bytes (length mode) |
| desc_write | input | 1 | 1 = write, 0 = read |
| desc_sparse | input | 1 | 1 = byte-pattern mode, 0 = length mode |
| desc_bmask | input | 32 | Byte pattern over the 32-byte window (sparse mode) |
| req_valid | output | 1 | Request offered |
| req_ready | input | 1 | Request taken by the link side |
| req_addr | output | 38 | Address bits 39:2 |
| req_kind | output | 2 | Request kind encoding (R3) |
| req_dcnt | output | 4 | Dword count minus one |
| req_bmask | output | 32 | Byte mask of a byte request |

## Verification
On every cycle the assertions check that dword requests stay inside their 64-byte block and carry no mask, and that byte reads use only the low nibble with a nonzero mask. They also check that a stalled request holds steady and that the descriptor side stays closed while a request is pending. Some behaviour can only be shown by the bench's scenarios: the exact split points, the maximal dword counts, ascending order, complete byte coverage, and the empty outcomes for zero length or zero pattern. The bench compares the full request sequence for each descriptor against a list it builds on its own, under random back-pressure.

// File: rtl/szsplit_pkg.sv
package szsplit_pkg;

   localparam int ADDR_W    = 40;
   localparam int DADDR_W   = ADDR_W - 2;
   localparam int WIN_W     = ADDR_W - 5;
   localparam int BMASK_W   = 32;
   localparam int DCNT_W    = 4;
   localparam int TAKE_W    = 7;

   typedef enum logic [1:0] {
      KIND_BRD = 2'd0,
      KIND_DRD = 2'd1,
      KIND_BWR = 2'd2,
      KIND_DWR = 2'd3
   } req_kind_e;

   typedef struct packed {
      logic [DADDR_W-1:0] daddr;
      req_kind_e          kind;
      logic [DCNT_W-1:0]  dcnt;
      logic [BMASK_W-1:0] bmask;
   } req_t;

   // contiguous run of 'take' enabled bytes starting at byte 'off' of a dword
   function automatic logic [3:0] run_mask4(input logic [1:0] off, input logic [2:0] take);
      logic [3:0] m;
      m = 4'd1 << take;
      m = m - 4'd1;
      return m << off;
   endfunction

endpackage

// File: rtl/szsplit_lenplan.sv
module szsplit_lenplan
   import szsplit_pkg::*;
#(
   parameter int LEN_W = 16
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [LEN_W-1:0]  remain,
   input  logic              is_wr,
   output req_t              piece,
   output logic [TAKE_W-1:0] take
);

   localparam int RDW_W = LEN_W - 2;

   logic [1:0]       off;
   logic             byte_mode;
   logic [2:0]       room_b;
   logic [2:0]       take_b;
   logic [3:0]       m4;
   logic [4:0]       dw_room;
   logic [RDW_W-1:0] rem_dw;
   logic [4:0]       dw_cnt;
   logic [4:0]       dw_cnt_m1;
   logic [31:0]      wr_mask;

   always_comb begin
      off       = cur_addr[1:0];
      byte_mode = (off != 2'd0) || (remain < LEN_W'(4));
      room_b    = 3'd4 - {1'b0, off};
      take_b    = (remain < LEN_W'(room_b)) ? remain[2:0] : room_b;
      m4        = run_mask4(off, take_b);
      wr_mask   = {28'd0, m4} << {cur_addr[4:2], 2'b00};

      dw_room   = 5'd16 - {1'b0, cur_addr[5:2]};
      rem_dw    = remain[LEN_W-1:2];
      dw_cnt    = (rem_dw < RDW_W'(dw_room)) ? rem_dw[4:0] : dw_room;
      dw_cnt_m1 = dw_cnt - 5'd1;

      piece.daddr = cur_addr[ADDR_W-1:2];
      if (byte_mode) begin
         piece.kind  = is_wr ? KIND_BWR : KIND_BRD;
         piece.dcnt  = '0;
         piece.bmask = is_wr ? wr_mask : {28'd0, m4};
         take        = {4'd0, take_b};
      end else begin
         piece.kind  = is_wr ? KIND_DWR : KIND_DRD;
         piece.dcnt  = dw_cnt_m1[3:0];
         piece.bmask = '0;
         take        = {dw_cnt, 2'b00};
      end
   end

endmodule

// File: rtl/szsplit_maskplan.sv
module szsplit_maskplan
   import szsplit_pkg::*;
#(
   parameter int NIBBLES = BMASK_W / 4
) (
   input  logic [WIN_W-1:0]   win_base,
   input  logic [BMASK_W-1:0] pattern,
   input  logic               is_wr,
   output req_t               piece,
   output logic [BMASK_W-1:0] pattern_next
);

   localparam int IDX_W = $clog2(NIBBLES);

   logic [NIBBLES-1:0] nz;
   logic [IDX_W-1:0]   idx;
   logic               found;
   logic [3:0]         nib;

   for (genvar g = 0; g < NIBBLES; g++) begin : g_nib
      assign nz[g] = |pattern[4*g +: 4];
   end

   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = 0; i < NIBBLES; i++) begin
         if (nz[i] && !found) begin
            idx   = IDX_W'(i);
            found = 1'b1;
         end
      end
      nib = pattern[{idx, 2'b00} +: 4];

      piece.daddr = {win_base, idx};
      piece.dcnt  = '0;
      if (is_wr) begin
         piece.kind   = KIND_BWR;
         piece.bmask  = pattern;
         pattern_next = '0;
      end else begin
         piece.kind   = KIND_BRD;
         piece.bmask  = {28'd0, nib};
         pattern_next = pattern & ~({28'd0, 4'hF} << {idx, 2'b00});
      end
   end

endmodule

// File: rtl/sized_req_splitter.sv
module sized_req_splitter
   import szsplit_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter bit SPARSE_EN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               desc_valid,
   output logic               desc_ready,
   input  logic [39:0]        desc_addr,
   input  logic [LEN_W-1:0]   desc_len,
   input  logic               desc_write,
   input  logic               desc_sparse,
   input  logic [31:0]        desc_bmask,
   output logic               req_valid,
   input  logic               req_ready,
   output logic [37:0]        req_addr,
   output logic [1:0]         req_kind,
   output logic [3:0]         req_dcnt,
   output logic [31:0]        req_bmask
);

   if (LEN_W < TAKE_W) begin : g_bad_len
      $error("sized_req_splitter: LEN_W must be at least %0d", TAKE_W);
   end
   if (ADDR_W != 40) begin : g_bad_addr
      $error("sized_req_splitter: address width must be 40");
   end

   logic               active;
   logic [ADDR_W-1:0]  cur_addr;
   logic [LEN_W-1:0]   remain;
   logic               is_wr;
   logic               sparse;
   logic [BMASK_W-1:0] pattern;

   req_t               len_piece;
   logic [TAKE_W-1:0]  len_take;
   req_t               msk_piece;
   logic [BMASK_W-1:0] pattern_next;
   req_t               piece;

   logic accept;
   logic fire;
   logic take_sparse;

   szsplit_lenplan #(.LEN_W(LEN_W)) u_lenplan (
      .cur_addr (cur_addr),
      .remain   (remain),
      .is_wr    (is_wr),
      .piece    (len_piece),
      .take     (len_take)
   );

   if (SPARSE_EN) begin : g_sparse
      szsplit_maskplan u_maskplan (
         .win_base     (cur_addr[ADDR_W-1:5]),
         .pattern      (pattern),
         .is_wr        (is_wr),
         .piece        (msk_piece),
         .pattern_next (pattern_next)
      );
      assign take_sparse = desc_sparse;
   end else begin : g_nosparse
      assign msk_piece    = '0;
      assign pattern_next = '0;
      assign take_sparse  = 1'b0;
   end

   assign piece      = sparse ? msk_piece : len_piece;
   assign desc_ready = !active;
   assign accept     = desc_valid && !active;
   assign fire       = active && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active   <= 1'b0;
         cur_addr <= '0;
         remain   <= '0;
         is_wr    <= 1'b0;
         sparse   <= 1'b0;
         pattern  <= '0;
      end else if (accept) begin
         cur_addr <= desc_addr;
         remain   <= desc_len;
         is_wr    <= desc_write;
         sparse   <= take_sparse;
         pattern  <= desc_bmask;
         active   <= take_sparse ? (desc_bmask != '0) : (desc_len != '0);
      end else if (fire) begin
         if (sparse) begin
            pattern <= pattern_next;
            active  <= (pattern_next != '0);
         end else begin
            cur_addr <= cur_addr + ADDR_W'(len_take);
            remain   <= remain - LEN_W'(len_take);
            active   <= (remain != LEN_W'(len_take));
         end
      end
   end

   assign req_valid = active;
   assign req_addr  = piece.daddr;
   assign req_kind  = piece.kind;
   assign req_dcnt  = piece.dcnt;
   assign req_bmask = piece.bmask;

endmodule

// File: rtl/sized_req_splitter_chk.sv
module sized_req_splitter_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        desc_ready,
   input logic        req_valid,
   input logic        req_ready,
   input logic [37:0] req_addr,
   input logic [1:0]  req_kind,
   input logic [3:0]  req_dcnt,
   input logic [31:0] req_bmask
);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_kind)
                                  && $stable(req_dcnt) && $stable(req_bmask));

   assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> !desc_ready);

   assert_dword_nomask_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind[0] |-> req_bmask == 32'd0);

   assert_no_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind[0] |-> ({1'b0, req_addr[3:0]} + {1'b0, req_dcnt}) <= 5'd15);

   assert_byte_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 2'd0 |-> req_bmask[31:4] == 28'd0 && req_bmask[3:0] != 4'd0
                                        && req_dcnt == 4'd0);

   assert_byte_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_kind == 2'd2 |-> req_bmask != 32'd0 && req_dcnt == 4'd0);

endmodule

bind sized_req_splitter sized_req_splitter_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .desc_ready (desc_ready),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .req_kind   (req_kind),
   .req_dcnt   (req_dcnt),
   .req_bmask  (req_bmask)
);

// File: tb/sized_req_splitter_bench.sv
module sized_req_splitter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int LEN_W      = 16;
   localparam int MAXQ       = 64;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              desc_valid;
   logic              desc_ready;
   logic [39:0]       desc_addr;
   logic [LEN_W-1:0]  desc_len;
   logic              desc_write;
   logic              desc_sparse;
   logic [31:0]       desc_bmask;
   logic              req_valid;
   logic              req_ready;
   logic [37:0]       req_addr;
   logic [1:0]        req_kind;
   logic [3:0]        req_dcnt;
   logic [31:0]       req_bmask;

   always #(CLK_PERIOD/2) clk = ~clk;

   sized_req_splitter #(.LEN_W(LEN_W)) u_sized_req_splitter (
      .clk(clk), .rst_n(rst_n),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
      .desc_len(desc_len), .desc_write(desc_write), .desc_sparse(desc_sparse),
      .desc_bmask(desc_bmask),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_kind(req_kind), .req_dcnt(req_dcnt), .req_bmask(req_bmask)
   );

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [37:0] e_addr [MAXQ];
   logic [1:0]  e_kind [MAXQ];
   logic [3:0]  e_dcnt [MAXQ];
   logic [31:0] e_mask [MAXQ];
   int          n_exp;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push(input logic [37:0] a, input logic [1:0] k,
                       input logic [3:0] c, input logic [31:0] m);
      if (n_exp < MAXQ) begin
         e_addr[n_exp] = a; e_kind[n_exp] = k; e_dcnt[n_exp] = c; e_mask[n_exp] = m;
         n_exp++;
      end
   endtask

   // expected list for length mode, built byte by byte / dword by dword
   task automatic build_len(input logic [39:0] a0, input int len, input bit wr);
      logic [39:0] a;
      logic [39:0] first;
      logic [31:0] m;
      int n;
      int c;
      a = a0; n = len; n_exp = 0;
      while (n > 0) begin
         first = a;
         if (a[1:0] != 2'd0 || n < 4) begin
            m = '0;
            do begin
               if (wr) m[a[4:0]] = 1'b1; else m[a[1:0]] = 1'b1;
               a = a + 40'd1; n--;
            end while (n > 0 && a[1:0] != 2'd0);
            push(first[39:2], wr ? 2'd2 : 2'd0, 4'd0, m);
         end else begin
            c = 0;
            do begin
               c++; a = a + 40'd4; n -= 4;
            end while (n >= 4 && a[5:0] != 6'd0);
            push(first[39:2], wr ? 2'd3 : 2'd1, 4'(c - 1), 32'd0);
         end
      end
   endtask

   task automatic build_sparse(input logic [39:0] a0, input logic [31:0] pm, input bit wr);
      bit done;
      n_exp = 0;
      done = 1'b0;
      for (int d = 0; d < 8; d++) begin
         if (pm[4*d +: 4] != 4'd0 && !done) begin
            if (wr) begin
               push({a0[39:5], 3'(d)}, 2'd2, 4'd0, pm);
               done = 1'b1;
            end else begin
               push({a0[39:5], 3'(d)}, 2'd0, 4'd0, {28'd0, pm[4*d +: 4]});
            end
         end
      end
   endtask

   task automatic run(input logic [39:0] a, input int len, input bit wr, input bit sp,
                      input logic [31:0] pm, input string tag_b, input string tag_d,
                      input string tag_end, input int rdy_pct);
      int got;
      bit stalled;
      logic [37:0] h_addr; logic [1:0] h_kind; logic [3:0] h_dcnt; logic [31:0] h_mask;
      if (sp) build_sparse(a, pm, wr); else build_len(a, len, wr);
      @(negedge clk);
      check(desc_ready == 1'b1, "R2", "desc_ready before offer", 64'(desc_ready), 64'd1);
      desc_addr = a; desc_len = LEN_W'(len); desc_write = wr; desc_sparse = sp;
      desc_bmask = pm; desc_valid = 1'b1;
      @(posedge clk);
      #1 desc_valid = 1'b0;
      got = 0; stalled = 1'b0;
      h_addr = '0; h_kind = '0; h_dcnt = '0; h_mask = '0;
      forever begin
         @(negedge clk);
         if (desc_ready && !req_valid) break;
         check(!(req_valid && desc_ready), "R2", "desc_ready while busy", 64'(desc_ready), 64'd0);
         if (stalled) begin
            check(req_valid && req_addr == h_addr && req_kind == h_kind && req_dcnt == h_dcnt
                  && req_bmask == h_mask, "R2", "stall hold addr", 64'(req_addr), 64'(h_addr));
         end
         req_ready = (($urandom % 100) < rdy_pct);
         stalled = 1'b0;
         if (req_valid) begin
            if (req_ready) begin
               if (got < n_exp) begin
                  // R3 field encodings, R7 order
                  check(req_addr == e_addr[got], e_kind[got][0] ? tag_d : tag_b, "addr",
                        64'(req_addr), 64'(e_addr[got]));
                  check(req_kind == e_kind[got], "R3", "kind", 64'(req_kind), 64'(e_kind[got]));
                  check(req_dcnt == e_dcnt[got], e_kind[got][0] ? tag_d : tag_b, "dcnt",
                        64'(req_dcnt), 64'(e_dcnt[got]));
                  check(req_bmask == e_mask[got], e_kind[got][0] ? "R3" : tag_b, "bmask",
                        64'(req_bmask), 64'(e_mask[got]));
               end else begin
                  check(1'b0, tag_end, "extra request addr", 64'(req_addr), 64'd0);
               end
               got++;
            end else begin
               stalled = 1'b1;
               h_addr = req_addr; h_kind = req_kind; h_dcnt = req_dcnt; h_mask = req_bmask;
            end
         end
      end
      req_ready = 1'b0;
      check(got == n_exp, tag_end, "request count", 64'(got), 64'(n_exp));
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; errors++;
         $display("FAIL R2 watchdog actual=%0d expected<150000", cycles);
         summary();
         $finish;
      end
   end

   initial begin
      logic [39:0] ra;
      int rl;
      void'($urandom(32'd2024));
      rst_n = 1'b0; desc_valid = 1'b0; desc_addr = '0; desc_len = '0; desc_write = 1'b0;
      desc_sparse = 1'b0; desc_bmask = '0; req_ready = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check(req_valid == 1'b0, "R1", "req_valid in reset", 64'(req_valid), 64'd0);
      check(desc_ready == 1'b1, "R1", "desc_ready in reset", 64'(desc_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_valid == 1'b0 && desc_ready == 1'b1, "R1", "idle after reset",
            64'({req_valid, desc_ready}), 64'd1);

      // directed corners
      run(40'h00_0000_1000, 0,   1'b0, 1'b0, 32'd0, "R6", "R5", "R8", 100);
      run(40'h12_3456_7840, 64,  1'b0, 1'b0, 32'd0, "R6", "R5", "R7", 100);
      run(40'h00_0000_0201, 3,   1'b0, 1'b0, 32'd0, "R6", "R5", "R7", 50);
      run(40'h00_0000_003C, 8,   1'b1, 1'b0, 32'd0, "R6", "R4", "R7", 60);
      run(40'h00_0000_011D, 13,  1'b1, 1'b0, 32'd0, "R6", "R5", "R7", 70);
      run(40'hFF_FFFF_0003, 200, 1'b0, 1'b0, 32'd0, "R6", "R5", "R7", 40);
      run(40'h00_0000_0007, 0,   1'b1, 1'b0, 32'd0, "R6", "R5", "R8", 100);
      run(40'h00_0000_0A1F, 0,   1'b0, 1'b1, 32'h0A00_0050, "R9", "R9", "R9", 50);
      run(40'h00_0000_0A00, 0,   1'b1, 1'b1, 32'h8000_0100, "R10", "R10", "R10", 50);
      run(40'h00_0000_0A00, 0,   1'b0, 1'b1, 32'd0, "R9", "R9", "R11", 100);
      run(40'h00_0000_0A00, 0,   1'b1, 1'b1, 32'd0, "R10", "R10", "R11", 100);

      // constrained random
      for (int i = 0; i < 160; i++) begin
         ra = {8'($urandom), $urandom};
         if ($urandom % 3 == 0) ra[5:0] = 6'(60 + ($urandom % 8));
         rl = ($urandom % 4 == 0) ? int'($urandom % 8) : int'($urandom % 300);
         if ($urandom % 5 == 0)
            run(ra, 0, 1'($urandom), 1'b1, $urandom & $urandom,
                "R9", "R10", "R7", 30 + int'($urandom % 70));
         else
            run(ra, rl, 1'($urandom), 1'b0, 32'd0, "R6", "R5", "R7", 30 + int'($urandom % 70));
      end

      summary();
      $finish;
   end

endmodule